// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address sequence for a four-beat burst into a synchronous memory. Two active-low address strobes start a burst. One comes from a processor and one from a controller. When either strobe is sampled low at a rising clock edge, the block captures the full external base address and clears its beat counter. On later edges the two low address bits step through a four-beat pattern. They step only when the active-low advance input is sampled low. When advance is high, the current address is held, which suspends the burst.

The order input selects the beat pattern. When it is low, the pattern is linear: the start offset plus the beat count, modulo four. When it is high, the pattern is interleaved: the start offset XOR the beat count. An unused order pin is meant to be tied high, so interleaved is the default. The upper address bits always come straight from the captured base. After the fourth beat the counter wraps, and the address returns to the start address. The memory array and the data paths sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the block clears its state. After that edge, `cur_addr` is 0 and `beat_idx` is 0.
- R2: If `proc_strobe_n` or `ctrl_strobe_n` is low at a clock edge, the block loads `base_addr`. After that edge, `cur_addr` equals the `base_addr` sampled at the edge and `beat_idx` is 0.
- R3: With `order_sel` low (linear), `cur_addr[1:0]` equals (start offset + `beat_idx`) mod 4. The start offset is bits [1:0] of the loaded base. Example: a start of 01 gives 01, 10, 11, 00.
- R4: With `order_sel` high (interleaved, the tie-high default), `cur_addr[1:0]` equals the start offset XOR `beat_idx`. Example: a start of 01 gives 01, 00, 11, 10.
- R5: Consider an edge with both strobes high. If `advance_n` is low, `beat_idx` increments by one. If `advance_n` is high, `beat_idx` and `cur_addr` are unchanged (suspend).
- R6: After the fourth beat, one more advance wraps `beat_idx` from 3 to 0. `cur_addr` then returns to the loaded base address.
- R7: A strobe takes priority over advance in the same cycle. A strobe in the middle of a burst restarts the sequence at beat 0 from the new base.
- R8: `cur_addr[ADDR_W-1:2]` always equals the upper bits of the last loaded base, whatever the beat or the order mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low; loads the base |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low; loads the base |
| advance_n | input | 1 | Beat advance, active low; high suspends |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| base_addr | input | ADDR_W | External base address |
| cur_addr | output | ADDR_W | Current burst address |
| beat_idx | output | BEAT_W | Beats taken since the last load |

## Verification
The assertions assume two things about the inputs: every input is a defined 0 or 1 at each clock edge, and `order_sel` is a valid level whenever the address is compared. They also take the start offset to be bits [1:0] of the base captured on the last strobe. The stimulus therefore changes inputs only on falling edges, and drives `order_sel` to a solid level in every cycle. It mixes both strobes, held and stepped beats, wraps past the fourth beat, and mode changes in the middle of a burst. A behavioural model of the beat count and the captured base is compared against both outputs on every cycle.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_idx
);
  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_lin;
  logic [BEAT_W-1:0] low_ilv;
  logic              load;

  assign load = ~proc_strobe_n | ~ctrl_strobe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= base_addr;
      beat_q  <= '0;
    end else if (!advance_n) begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign low_lin  = start_q[BEAT_W-1:0] + beat_q;
  assign low_ilv  = start_q[BEAT_W-1:0] ^ beat_q;
  assign cur_addr = {start_q[ADDR_W-1:BEAT_W], order_sel ? low_ilv : low_lin};
  assign beat_idx = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              advance_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [BEAT_W-1:0] beat_idx
);
  logic              ld;
  logic [BEAT_W-1:0] seen_start;

  assign ld = !proc_strobe_n || !ctrl_strobe_n;

  always_ff @(posedge clk) begin
    if (rst) seen_start <= '0;
    else if (ld) seen_start <= base_addr[BEAT_W-1:0];
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat_idx == '0));

  a_r2_load_base: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cur_addr == $past(base_addr) && beat_idx == '0));

  a_r3_linear_order: assert property (@(posedge clk) disable iff (rst)
    !order_sel |-> cur_addr[BEAT_W-1:0] == BEAT_W'(seen_start + beat_idx));

  a_r4_interleave_order: assert property (@(posedge clk) disable iff (rst)
    order_sel |-> cur_addr[BEAT_W-1:0] == (seen_start ^ beat_idx));

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!ld && !advance_n) |=> beat_idx == BEAT_W'($past(beat_idx) + 1));

  a_r5_suspend: assert property (@(posedge clk) disable iff (rst)
    (!ld && advance_n) |=> $stable(beat_idx));

  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    (ld && !advance_n) |=> beat_idx == '0);

  a_r8_upper_kept: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
  .advance_n(advance_n), .order_sel(order_sel), .base_addr(base_addr),
  .cur_addr(cur_addr), .beat_idx(beat_idx)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, osel = 1'b1;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat_idx;

  int            n_cmp = 0, n_bad = 0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic [31:0]   lfsr = 32'h1ACE_5EED;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst(rst), .proc_strobe_n(ps_n), .ctrl_strobe_n(cs_n),
    .advance_n(adv_n), .order_sel(osel), .base_addr(base),
    .cur_addr(cur_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] exp_addr();
    int lo;
    lo = osel ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic compare(string tag);
    n_cmp++;
    if (cur_addr !== exp_addr() || beat_idx !== 2'(m_beat)) begin
      n_bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat_idx, exp_addr(), m_beat);
    end
  endtask

  task automatic tick(input logic p, input logic c, input logic a, input logic o,
                      input logic [AW-1:0] b, input string tag);
    ps_n = p; cs_n = c; adv_n = a; osel = o; base = b;
    @(posedge clk);
    if (rst) begin m_base = '0; m_beat = 0; end
    else if (!p || !c) begin m_base = b; m_beat = 0; end
    else if (!a) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(1, 1, 1, 1, 18'h3FFFF, "R1 reset");
    tick(0, 1, 0, 1, 18'h12345, "R1 reset beats strobe");
    rst = 1'b0;
    // R2 processor strobe, R3 linear from 01, R6 wrap
    tick(0, 1, 1, 0, 18'h2A5F1, "R2 proc load");
    for (int i = 0; i < 4; i++) tick(1, 1, 0, 0, 18'h00000, "R3 R6 linear step");
    // R5 suspend
    tick(1, 1, 0, 0, '0, "R5 step");
    for (int i = 0; i < 3; i++) tick(1, 1, 1, 0, 18'h3FFFF, "R5 suspend");
    // R4 interleaved from 01 via controller strobe
    tick(1, 0, 1, 1, 18'h15501, "R2 ctrl load");
    for (int i = 0; i < 5; i++) tick(1, 1, 0, 1, '0, "R4 R6 interleave step");
    // R7 load beats advance, restart mid burst
    tick(1, 1, 0, 1, '0, "R5 step");
    tick(0, 0, 0, 1, 18'h0BEE2, "R7 load over advance");
    tick(1, 1, 0, 0, '0, "R3 linear from 10");
    tick(1, 0, 0, 0, 18'h3C003, "R7 restart mid burst");
    tick(1, 1, 0, 1, '0, "R4 interleave from 11");
    tick(1, 1, 1, 0, '0, "R8 mode swap keeps upper");
    // mixed stimulus
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tick(lfsr[3:0] != 4'h0, lfsr[7:4] != 4'h1, lfsr[8] & lfsr[9], lfsr[10],
           lfsr[31:14], "R8 mixed");
    end
    rst = 1'b1;
    tick(1, 1, 0, 1, '0, "R1 reset again");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule